// File: doc/BRIEF.md
# Flush-Delay Launch/Capture Sequencer

This block runs delay-line measurements on a scan chain built from two-clock master/slave latches. For every trial it first raises both latch clocks and drives scan-in low, so the chain becomes transparent and fills with zeros. With both clocks still high it then raises scan-in once, which sends a single rising edge down the chain. After a programmed number of system-clock ticks it drops clock A, and the latches freeze wherever the edge has reached.

It then reads the frozen chain out serially with non-overlapping A and B pulses and counts the ones it samples on scan-out. That count is how many stages the edge crossed in the interval. It reports the count together with the interval index and the repetition index.

A sweep is started with one pulse. It walks the interval index from zero up to a configured last value. Each interval runs a configured number of repeated trials, and the interval in ticks is the index times a fixed step parameter. The sweep ends early when a trial finds the whole chain full of ones.

Top module: `flush_sweep_top`

## Requirements
- R1: While reset is asserted, and after it until a sweep starts, scanIn, clkA, clkB, trialValid and done are all low.
- R2: Every trial starts with exactly FLUSH_TICKS cycles of clkA=1, clkB=1, scanIn=0 directly before the launch, which leaves the chain all zeros.
- R3: scanIn rises exactly once per trial, while clkB is high. It stays high, with clkB high, until the capture.
- R4: clkA falls exactly idx*TICKS_PER_STEP cycles after scanIn rises. For idx 0 it falls in the same cycle that scanIn rises. A fall of clkA while clkB is high happens only with scanIn high.
- R5: After capture the chain is read with CHAIN_LEN pulses on clkA, each taken while clkB is low. The clocks are never both high during readout, and clkB only falls while clkA is low.
- R6: trialValid is a one-cycle strobe. trialOnes gives the number of ones sampled on scanOut in that trial, which for an ideal one-stage-per-tick chain is min(idx*TICKS_PER_STEP, CHAIN_LEN).
- R7: Trials run with the repetition index in the inner loop (0 to cfgReps-1) and the interval index in the outer loop (0 to cfgLastIdx). A cfgReps value of 0 is taken as 1.
- R8: A trial whose trialOnes equals CHAIN_LEN is the last trial of the sweep.
- R9: done pulses for one cycle, in the same cycle as the final trialValid of a sweep, and never at any other time.
- R10: The configuration is captured when start is accepted. Both start and configuration changes are ignored while a sweep runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick is the timing unit |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a sweep when idle |
| cfgLastIdx | input | IDX_W | Last interval index of the sweep |
| cfgReps | input | REP_W | Trials per interval (0 treated as 1) |
| scanOut | input | 1 | Serial output of the scan chain |
| scanIn | output | 1 | Serial input driven into the chain |
| clkA | output | 1 | Master latch clock |
| clkB | output | 1 | Slave latch clock |
| trialValid | output | 1 | One-cycle strobe per finished trial |
| trialIdx | output | IDX_W | Interval index of the reported trial |
| trialRep | output | REP_W | Repetition index of the reported trial |
| trialOnes | output | clog2(CHAIN_LEN+1) | Count of ones read from the chain |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The cases that are hardest to reach from the ports are the early stop and start requests that arrive during a sweep. Reaching the early stop needs a chain that actually fills, so the bench includes a behavioral two-latch chain that advances one stage per tick in flush mode. Its step and length are chosen so that the edge fills the chain at a known index, and the configured last index lies beyond that index. A second start with different configuration is issued in the middle of that sweep, and the bench expects the order of trials to be unchanged. Index zero, where launch and capture fall in the same cycle, is covered by every sweep.

// File: rtl/flush_sweep_pkg.sv
package flush_sweep_pkg;

  // Per-cycle commands from control to datapath. The drv* fields give the
  // values the chain pins take on the next clock edge.
  typedef struct packed {
    logic drvA;
    logic drvB;
    logic drvIn;
    logic clearOnes;
    logic sample;
    logic report;
    logic finish;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_PROP,
    ST_SHIFT,
    ST_REPORT
  } seqState_t;

endpackage

// File: rtl/flush_sweep_ctrl.sv
module flush_sweep_ctrl
  import flush_sweep_pkg::*;
#(
  parameter int CHAIN_LEN      = 12000,
  parameter int TICKS_PER_STEP = 1,
  parameter int FLUSH_TICKS    = 12032,
  parameter int IDX_W          = 8,
  parameter int REP_W          = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] cfgLastIdx,
  input  logic [REP_W-1:0] cfgReps,
  input  logic             allOnes,
  output seqStrobe_t       stb,
  output logic [IDX_W-1:0] curIdx,
  output logic [REP_W-1:0] curRep
);

  localparam int PROP_MAX = ((1 << IDX_W) - 1) * TICKS_PER_STEP;
  localparam int TMR_MAX  = (FLUSH_TICKS > PROP_MAX) ? FLUSH_TICKS : PROP_MAX;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int BIT_W    = $clog2(CHAIN_LEN);

  seqState_t        state;
  logic [TMR_W-1:0] tmr;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       phase;
  logic [IDX_W-1:0] lastIdxR;
  logic [REP_W-1:0] lastRepR;
  logic [TMR_W-1:0] target;
  logic             lastTrial;

  assign target    = TMR_W'(curIdx) * TMR_W'(TICKS_PER_STEP);
  assign lastTrial = allOnes || ((curIdx == lastIdxR) && (curRep == lastRepR));

  // Strobe generation: pure decode of the current state and counters.
  always_comb begin
    stb = '0;
    unique case (state)
      ST_FLUSH: begin
        stb.drvA      = 1'b1;
        stb.drvB      = 1'b1;
        stb.clearOnes = (tmr == '0);
      end
      ST_PROP: begin
        stb.drvIn = 1'b1;
        stb.drvB  = 1'b1;
        stb.drvA  = (tmr < target);
      end
      ST_SHIFT: begin
        unique case (phase)
          2'd1: begin
            stb.sample = 1'b1;
            stb.drvA   = 1'b1;
          end
          2'd3:    stb.drvB = 1'b1;
          default: ;
        endcase
      end
      ST_REPORT: begin
        stb.report = 1'b1;
        stb.finish = lastTrial;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      bitCnt   <= '0;
      phase    <= '0;
      curIdx   <= '0;
      curRep   <= '0;
      lastIdxR <= '0;
      lastRepR <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lastIdxR <= cfgLastIdx;
            lastRepR <= (cfgReps == '0) ? '0 : cfgReps - 1'b1;
            curIdx   <= '0;
            curRep   <= '0;
            tmr      <= '0;
            state    <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (tmr == TMR_W'(FLUSH_TICKS - 1)) begin
            tmr   <= '0;
            state <= ST_PROP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PROP: begin
          if (tmr == target) begin
            phase  <= '0;
            bitCnt <= '0;
            state  <= ST_SHIFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SHIFT: begin
          phase <= phase + 1'b1;
          if (phase == 2'd3) begin
            if (bitCnt == BIT_W'(CHAIN_LEN - 1)) state <= ST_REPORT;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_REPORT: begin
          tmr <= '0;
          if (lastTrial) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_FLUSH;
            if (curRep == lastRepR) begin
              curRep <= '0;
              curIdx <= curIdx + 1'b1;
            end else begin
              curRep <= curRep + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flush_sweep_dpath.sv
module flush_sweep_dpath
  import flush_sweep_pkg::*;
#(
  parameter int CHAIN_LEN = 12000,
  parameter int IDX_W     = 8,
  parameter int REP_W     = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobe_t                     stb,
  input  logic [IDX_W-1:0]               curIdx,
  input  logic [REP_W-1:0]               curRep,
  input  logic                           scanOut,
  output logic                           allOnes,
  output logic                           scanIn,
  output logic                           clkA,
  output logic                           clkB,
  output logic                           trialValid,
  output logic [IDX_W-1:0]               trialIdx,
  output logic [REP_W-1:0]               trialRep,
  output logic [$clog2(CHAIN_LEN+1)-1:0] trialOnes,
  output logic                           done
);

  localparam int ONES_W = $clog2(CHAIN_LEN + 1);

  logic [ONES_W-1:0] onesCnt;

  assign allOnes = (onesCnt == ONES_W'(CHAIN_LEN));

  // Chain pins: registered so the latch clocks come straight from flops.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIn <= 1'b0;
      clkA   <= 1'b0;
      clkB   <= 1'b0;
    end else begin
      scanIn <= stb.drvIn;
      clkA   <= stb.drvA;
      clkB   <= stb.drvB;
    end
  end

  // Ones counter fed by the serial readout.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
    end else if (stb.clearOnes) begin
      onesCnt <= '0;
    end else if (stb.sample) begin
      onesCnt <= onesCnt + ONES_W'(scanOut);
    end
  end

  // Result registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialValid <= 1'b0;
      trialIdx   <= '0;
      trialRep   <= '0;
      trialOnes  <= '0;
      done       <= 1'b0;
    end else begin
      trialValid <= stb.report;
      done       <= stb.report & stb.finish;
      if (stb.report) begin
        trialIdx  <= curIdx;
        trialRep  <= curRep;
        trialOnes <= onesCnt;
      end
    end
  end

endmodule

// File: rtl/flush_sweep_top.sv
module flush_sweep_top
  import flush_sweep_pkg::*;
#(
  parameter int CHAIN_LEN      = 12000,
  parameter int TICKS_PER_STEP = 1,
  parameter int FLUSH_TICKS    = 12032,
  parameter int IDX_W          = 8,
  parameter int REP_W          = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [IDX_W-1:0]               cfgLastIdx,
  input  logic [REP_W-1:0]               cfgReps,
  input  logic                           scanOut,
  output logic                           scanIn,
  output logic                           clkA,
  output logic                           clkB,
  output logic                           trialValid,
  output logic [IDX_W-1:0]               trialIdx,
  output logic [REP_W-1:0]               trialRep,
  output logic [$clog2(CHAIN_LEN+1)-1:0] trialOnes,
  output logic                           done
);

  seqStrobe_t       stb;
  logic [IDX_W-1:0] curIdx;
  logic [REP_W-1:0] curRep;
  logic             allOnes;

  flush_sweep_ctrl #(
    .CHAIN_LEN     (CHAIN_LEN),
    .TICKS_PER_STEP(TICKS_PER_STEP),
    .FLUSH_TICKS   (FLUSH_TICKS),
    .IDX_W         (IDX_W),
    .REP_W         (REP_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cfgLastIdx(cfgLastIdx),
    .cfgReps   (cfgReps),
    .allOnes   (allOnes),
    .stb       (stb),
    .curIdx    (curIdx),
    .curRep    (curRep)
  );

  flush_sweep_dpath #(
    .CHAIN_LEN(CHAIN_LEN),
    .IDX_W    (IDX_W),
    .REP_W    (REP_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .curIdx    (curIdx),
    .curRep    (curRep),
    .scanOut   (scanOut),
    .allOnes   (allOnes),
    .scanIn    (scanIn),
    .clkA      (clkA),
    .clkB      (clkB),
    .trialValid(trialValid),
    .trialIdx  (trialIdx),
    .trialRep  (trialRep),
    .trialOnes (trialOnes),
    .done      (done)
  );

endmodule

// File: rtl/flush_sweep_chk.sv
module flush_sweep_chk #(
  parameter int CHAIN_LEN = 12000
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           scanIn,
  input logic                           clkA,
  input logic                           clkB,
  input logic                           trialValid,
  input logic [$clog2(CHAIN_LEN+1)-1:0] trialOnes,
  input logic                           done
);

  localparam int ONES_W = $clog2(CHAIN_LEN + 1);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!scanIn && !clkA && !clkB && !trialValid && !done)
        else $error("outputs active during reset");
    end
  end

  assert_launch_under_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    scanIn |-> clkB);

  assert_capture_holds_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkA) && clkB) |-> scanIn);

  assert_b_falls_a_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkB) |-> !clkA);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    trialValid |=> !trialValid);

  assert_ones_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    trialValid |-> (trialOnes <= ONES_W'(CHAIN_LEN)));

  assert_full_chain_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trialValid && (trialOnes == ONES_W'(CHAIN_LEN))) |-> done);

  assert_done_with_trial_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> trialValid);

endmodule

bind flush_sweep_top flush_sweep_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .scanIn    (scanIn),
  .clkA      (clkA),
  .clkB      (clkB),
  .trialValid(trialValid),
  .trialOnes (trialOnes),
  .done      (done)
);

// File: tb/flush_sweep_top_test.sv
module flush_sweep_top_test;

  localparam int N     = 16;
  localparam int TICKS = 2;
  localparam int FLUSH = 18;
  localparam int IDX_W = 5;
  localparam int REP_W = 3;
  localparam int OW    = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic start = 1'b0;
  logic [IDX_W-1:0] cfgLastIdx = '0;
  logic [REP_W-1:0] cfgReps = '0;
  logic scanOut;
  logic scanIn, clkA, clkB, trialValid, done;
  logic [IDX_W-1:0] trialIdx;
  logic [REP_W-1:0] trialRep;
  logic [OW-1:0] trialOnes;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flush_sweep_top #(
    .CHAIN_LEN(N), .TICKS_PER_STEP(TICKS), .FLUSH_TICKS(FLUSH),
    .IDX_W(IDX_W), .REP_W(REP_W)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgLastIdx(cfgLastIdx),
    .cfgReps(cfgReps), .scanOut(scanOut), .scanIn(scanIn), .clkA(clkA),
    .clkB(clkB), .trialValid(trialValid), .trialIdx(trialIdx),
    .trialRep(trialRep), .trialOnes(trialOnes), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioral two-latch chain: one stage per tick when both clocks are high.
  logic m [N];
  logic s [N];
  assign scanOut = s[N-1];

  initial begin
    for (int i = 0; i < N; i++) begin
      m[i] = 1'b1;
      s[i] = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (clkA && clkB) begin
      for (int i = N - 1; i >= 0; i--) begin
        s[i] = (i == 0) ? scanIn : s[i-1];
        m[i] = s[i];
      end
    end else if (clkA) begin
      for (int i = N - 1; i >= 0; i--) m[i] = (i == 0) ? scanIn : s[i-1];
    end else if (clkB) begin
      for (int i = 0; i < N; i++) s[i] = m[i];
    end
  end

  // Expected-sequence state and monitor.
  int expIdx, expRep, expLastIdx, expLastRep, trialsSeen, donesSeen;
  int flushRun = 0, propCnt = 0, aPulses = 0, rises = 0, overlap = 0;
  bit launched = 0;
  logic prevA = 0, prevIn = 0;

  always @(posedge clk) begin
    #5;
    if (rstN) begin
      if (scanIn && !prevIn) begin
        int ones0;
        ones0 = 0;
        for (int i = 0; i < N; i++) ones0 += int'(m[i]) + int'(s[i]);
        chk(flushRun == FLUSH, "R2 flush run before launch", flushRun, FLUSH);
        chk(ones0 == 0, "R2 chain clear at launch", ones0, 0);
        propCnt  = clkA ? 1 : 0;
        aPulses  = 0;
        launched = 1;
        rises++;
      end else if (scanIn && clkA) begin
        propCnt++;
      end
      if (clkA && clkB && !scanIn) flushRun++;
      else flushRun = 0;
      if (launched && clkA && clkB && !scanIn) overlap++;
      if (clkA && !prevA && !clkB) aPulses++;
      if (trialValid) begin
        int expOnes;
        bit expDone;
        expOnes = (expIdx * TICKS < N) ? expIdx * TICKS : N;
        expDone = (expOnes == N) || (expIdx == expLastIdx && expRep == expLastRep);
        chk(int'(trialIdx) == expIdx, "R7 interval index", int'(trialIdx), expIdx);
        chk(int'(trialRep) == expRep, "R7 repetition index", int'(trialRep), expRep);
        chk(int'(trialOnes) == expOnes, "R6 ones count", int'(trialOnes), expOnes);
        chk(propCnt == expIdx * TICKS, "R4 launch-to-capture ticks", propCnt, expIdx * TICKS);
        chk(rises == 1, "R3 single launch edge", rises, 1);
        chk(aPulses == N, "R5 readout A pulses", aPulses, N);
        chk(overlap == 0, "R5 clocks overlap in readout", overlap, 0);
        chk(done == expDone, expOnes == N ? "R8 early stop" : "R9 done at last trial",
            int'(done), int'(expDone));
        trialsSeen++;
        if (done) donesSeen++;
        if (expRep == expLastRep) begin
          expRep = 0;
          expIdx++;
        end else begin
          expRep++;
        end
        launched = 0;
        rises    = 0;
        overlap  = 0;
      end else if (done) begin
        chk(0, "R9 done without trial", 1, 0);
      end
      prevA  = clkA;
      prevIn = scanIn;
    end
  end

  task automatic run_sweep(input int lastIdx, input int reps, input int expTrials,
                           input bit disturb);
    int cyc;
    cfgLastIdx = IDX_W'(lastIdx);
    cfgReps    = REP_W'(reps);
    expIdx     = 0;
    expRep     = 0;
    expLastIdx = lastIdx;
    expLastRep = (reps == 0) ? 0 : reps - 1;
    trialsSeen = 0;
    donesSeen  = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (donesSeen == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 300) begin
        cfgLastIdx = IDX_W'(1);
        cfgReps    = REP_W'(1);
        start      = 1'b1;
      end else if (disturb && cyc == 301) begin
        start = 1'b0;
      end
    end
    chk(cyc < 20000, "R9 sweep finished", cyc, 0);
    repeat (40) @(negedge clk);
    chk(trialsSeen == expTrials, disturb ? "R10 trial count after mid-sweep start"
                                         : "R7 trial count", trialsSeen, expTrials);
    chk(donesSeen == 1, "R9 single done", donesSeen, 1);
    chk(!scanIn && !clkA && !clkB, "R1 idle after sweep", int'({scanIn, clkA, clkB}), 0);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scanIn && !clkA && !clkB && !trialValid && !done, "R1 reset state",
        int'({scanIn, clkA, clkB, trialValid, done}), 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    chk(!scanIn && !clkA && !clkB && !trialValid && !done, "R1 idle before start",
        int'({scanIn, clkA, clkB, trialValid, done}), 0);
    // Edge fills the chain at index 8: stop after its first repetition.
    run_sweep(10, 3, 25, 1'b1);
    // Normal completion, partial fill at the end.
    run_sweep(3, 2, 8, 1'b0);
    // cfgReps of 0 runs one trial per interval.
    run_sweep(2, 0, 3, 1'b0);
    // Largest last index, early stop again.
    run_sweep(31, 1, 9, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule